// File: doc/BRIEF.md
# Multiprocessor Serial Port Receiver

This block is the receive half of an asynchronous serial port meant for multi-drop links where one master talks to several slaves over a shared line. The serial line is sampled on a baud-rate oversampling tick. A start bit is found on a falling edge, and every bit is settled by a vote of three samples taken around its centre. Eight data bits are collected least significant bit first. In the nine-bit framings a ninth bit follows, and then a stop bit.

At the middle of the stop bit the block decides whether the frame is delivered. The decision depends on the framing mode, on whether address filtering is switched on, on the ninth bit or the stop bit, and on an address comparison. That comparison accepts either the station's own address or the broadcast address, and both are formed from an address register and a mask register. A slave can therefore sleep through data meant for other stations and wake only when it is addressed. A framing-error flag records any stop bit that is sampled low, and it stays set until software clears it.

Top module: `mpser_rx`

## Requirements
- R1: `mode[1]`=0 (mode 01) selects a frame of start bit, 8 data bits sent LSB first, and stop bit. `mode[1]`=1 (modes 10 and 11) inserts a ninth bit between the data bits and the stop bit.
- R2: A start is recognised only on a high-to-low change between two consecutive ticks while the receiver is idle. If the vote in the start bit gives high, the block returns to idle and no output changes.
- R3: Each bit takes the majority of the line samples at the ticks numbered OSR/2-1, OSR/2 and OSR/2+1 of that bit, where the tick that saw the falling edge is tick 0. A single wrong sample, including the centre one, does not change the received value.
- R4: The frame decision is made on tick OSR/2+1 of the stop bit. `rx_flag`, `rx_byte` and `rx_bit9` take their new values on that clock edge.
- R5: In the nine-bit modes with `addr_en`=1, a frame is delivered only if its ninth bit is 1 and its byte matches the given or broadcast address.
- R6: In mode 01 with `addr_en`=1, a frame is delivered only if its stop bit is 1 and its byte matches the given or broadcast address. With `addr_en`=0, every completed frame is delivered in any mode.
- R7: A byte matches the given address when ((byte XOR `own_addr`) AND `addr_mask`) is 0. It matches the broadcast address B = `own_addr` OR `addr_mask` when every bit that is 1 in B is also 1 in the byte.
- R8: On delivery, `rx_bit9` takes the received ninth bit in the nine-bit modes and the received stop bit in mode 01.
- R9: `ferr_flag` is set by any completed frame whose stop bit is sampled 0, whether or not the frame is delivered. Valid frames do not clear it. Only `ferr_clr` clears it, and a new error wins over a clear in the same cycle.
- R10: Nothing is received while `rx_en`=0 or `mode`=00. Dropping `rx_en` in the middle of a frame abandons that frame.
- R11: `rx_flag` stays set until `flag_clr`. A frame that completes while `rx_flag` is set is discarded, and `rx_byte` and `rx_bit9` keep their values.
- R12: After reset, `rx_byte`, `rx_bit9`, `rx_flag` and `ferr_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| tick | input | 1 | oversampling strobe, OSR per bit time |
| rxd | input | 1 | serial line, already synchronous to clk |
| rx_en | input | 1 | reception enable |
| mode | input | 2 | framing mode: 00 off, 01 eight-bit, 10 and 11 nine-bit |
| addr_en | input | 1 | address filtering enable |
| own_addr | input | DW | station address |
| addr_mask | input | DW | address mask, a 0 bit is don't-care |
| flag_clr | input | 1 | clears rx_flag |
| ferr_clr | input | 1 | clears ferr_flag |
| rx_byte | output | DW | last delivered data byte |
| rx_bit9 | output | 1 | ninth bit or stop bit of the last delivered frame |
| rx_flag | output | 1 | frame delivered, sticky |
| ferr_flag | output | 1 | framing error, sticky |

## Verification
The bench builds the block with OSR=4 and DW=8 and pulses the tick on every second clock. A frame is then about a hundred clocks long, so every mode, filter outcome, glitch position and abort case fits well inside the run. With OSR=4 the decision tick and the last tick of a bit are the same tick, which tests that the voting window and the bit boundary agree. The filter cases use a mask with don't-care bits, so the given-address and broadcast paths are each the only reason a particular frame is accepted.

// File: rtl/mpser_pkg.sv
package mpser_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_NINTH,
    RX_STOP
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/mpser_sampler.sv
module mpser_sampler
  import mpser_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rxd,
  input  logic run,
  output logic fall,
  output logic dec,
  output logic dec_val,
  output logic eob
);
  localparam int CW = $clog2(OSR);
  localparam int MID = OSR / 2;
  localparam logic [CW-1:0] S_A   = CW'(MID - 1);
  localparam logic [CW-1:0] S_B   = CW'(MID);
  localparam logic [CW-1:0] S_C   = CW'(MID + 1);
  localparam logic [CW-1:0] S_END = CW'(OSR - 1);

  logic [CW-1:0] cnt;
  logic          prev, s_a, s_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= CW'(1);
      prev <= 1'b1;
      s_a  <= 1'b0;
      s_b  <= 1'b0;
    end else begin
      if (tick) prev <= rxd;
      if (!run) begin
        cnt <= CW'(1);
      end else if (tick) begin
        if (cnt == S_END) cnt <= '0;
        else              cnt <= cnt + 1'b1;
        if (cnt == S_A) s_a <= rxd;
        if (cnt == S_B) s_b <= rxd;
      end
    end
  end

  assign fall    = tick && prev && !rxd;
  assign dec     = tick && run && (cnt == S_C);
  assign eob     = tick && run && (cnt == S_END);
  assign dec_val = maj3(s_a, s_b, rxd);

  // R2: a frame is only entered from a sampled falling edge
  assert_start_on_edge_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(fall));
endmodule

// File: rtl/mpser_framer.sv
module mpser_framer
  import mpser_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          nine,
  input  logic          fall,
  input  logic          dec,
  input  logic          dec_val,
  input  logic          eob,
  output logic          run,
  output logic          done,
  output logic          stop_val,
  output logic [DW-1:0] data,
  output logic          bit9
);
  localparam int IW = $clog2(DW);
  localparam logic [IW-1:0] LAST = IW'(DW - 1);

  rx_state_t     state;
  logic [IW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      idx   <= '0;
      data  <= '0;
      bit9  <= 1'b0;
    end else if (!active) begin
      state <= RX_IDLE;
    end else begin
      case (state)
        RX_IDLE: if (fall) begin
          state <= RX_START;
          idx   <= '0;
        end
        RX_START: begin
          if (dec && dec_val) state <= RX_IDLE;
          else if (eob)       state <= RX_DATA;
        end
        RX_DATA: begin
          if (dec) data <= {dec_val, data[DW-1:1]};
          if (eob) begin
            if (idx == LAST) state <= nine ? RX_NINTH : RX_STOP;
            else             idx <= idx + 1'b1;
          end
        end
        RX_NINTH: begin
          if (dec) bit9 <= dec_val;
          if (eob) state <= RX_STOP;
        end
        RX_STOP: if (dec) state <= RX_IDLE;
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign run      = (state != RX_IDLE);
  assign done     = (state == RX_STOP) && dec;
  assign stop_val = dec_val;

  // R10: disabling reception forces the receiver back to idle
  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !active |=> !run);
  // R4: the frame ends at the stop-bit decision
  assert_done_ends_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !run);
endmodule

// File: rtl/mpser_filter.sv
module mpser_filter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic          stop_val,
  input  logic [DW-1:0] data,
  input  logic          bit9,
  input  logic          nine,
  input  logic          addr_en,
  input  logic [DW-1:0] own_addr,
  input  logic [DW-1:0] addr_mask,
  input  logic          flag_clr,
  input  logic          ferr_clr,
  output logic [DW-1:0] rx_byte,
  output logic          rx_bit9,
  output logic          rx_flag,
  output logic          ferr_flag
);
  logic [DW-1:0] bcast;
  logic          given_hit, bcast_hit, qual_bit, qual, busy, take;

  always_comb begin
    bcast     = own_addr | addr_mask;
    given_hit = ((data ^ own_addr) & addr_mask) == '0;
    bcast_hit = (data & bcast) == bcast;
    qual_bit  = nine ? bit9 : stop_val;
    qual      = !addr_en || (qual_bit && (given_hit || bcast_hit));
    busy      = rx_flag && !flag_clr;
    take      = done && qual && !busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_byte   <= '0;
      rx_bit9   <= 1'b0;
      rx_flag   <= 1'b0;
      ferr_flag <= 1'b0;
    end else begin
      if (take) begin
        rx_byte <= data;
        rx_bit9 <= qual_bit;
        rx_flag <= 1'b1;
      end else if (flag_clr) begin
        rx_flag <= 1'b0;
      end
      if (done && !stop_val) ferr_flag <= 1'b1;
      else if (ferr_clr)     ferr_flag <= 1'b0;
    end
  end

  // R11: flag is sticky and the held frame is not overwritten
  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_flag && !flag_clr) |=> rx_flag);
  assert_no_overwrite_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_flag && !flag_clr) |=> ($stable(rx_byte) && $stable(rx_bit9)));
  // R9: framing error is sticky and has a bad stop bit as its only cause
  assert_ferr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (ferr_flag && !ferr_clr) |=> ferr_flag);
  assert_ferr_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(ferr_flag) |-> $past(done && !stop_val));
  // R4: delivery only at a stop-bit decision
  assert_flag_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_flag) |-> $past(done));
endmodule

// File: rtl/mpser_rx.sv
module mpser_rx #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic          rx_en,
  input  logic [1:0]    mode,
  input  logic          addr_en,
  input  logic [DW-1:0] own_addr,
  input  logic [DW-1:0] addr_mask,
  input  logic          flag_clr,
  input  logic          ferr_clr,
  output logic [DW-1:0] rx_byte,
  output logic          rx_bit9,
  output logic          rx_flag,
  output logic          ferr_flag
);
  logic          active, nine;
  logic          fall, dec, dec_val, eob;
  logic          run, done, stop_val, bit9;
  logic [DW-1:0] data;

  assign active = rx_en && (mode != 2'b00);
  assign nine   = mode[1];

  mpser_sampler #(.OSR(OSR)) u_samp (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .run(run),
    .fall(fall), .dec(dec), .dec_val(dec_val), .eob(eob)
  );

  mpser_framer #(.DW(DW)) u_frm (
    .clk(clk), .rst(rst), .active(active), .nine(nine),
    .fall(fall), .dec(dec), .dec_val(dec_val), .eob(eob),
    .run(run), .done(done), .stop_val(stop_val), .data(data), .bit9(bit9)
  );

  mpser_filter #(.DW(DW)) u_flt (
    .clk(clk), .rst(rst), .done(done), .stop_val(stop_val), .data(data),
    .bit9(bit9), .nine(nine), .addr_en(addr_en), .own_addr(own_addr),
    .addr_mask(addr_mask), .flag_clr(flag_clr), .ferr_clr(ferr_clr),
    .rx_byte(rx_byte), .rx_bit9(rx_bit9), .rx_flag(rx_flag),
    .ferr_flag(ferr_flag)
  );
endmodule

// File: tb/sim_mpser_rx.sv
module sim_mpser_rx;
  localparam int CLK_PERIOD = 10;
  localparam int OSR_B      = 4;
  localparam int DECK       = OSR_B / 2 + 1;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst, tick, rxd, rx_en, addr_en, flag_clr, ferr_clr;
  logic [1:0] mode;
  logic [7:0] own, mask;
  logic [7:0] rx_byte;
  logic       rx_bit9, rx_flag, ferr_flag;

  logic [7:0] e_byte = 8'h00;
  logic       e_b9 = 1'b0, e_flag = 1'b0, e_ferr = 1'b0;
  int         total = 0, bad = 0;
  bit         mon_on = 1'b0;
  string      cur = "R12";

  always #(CLK_PERIOD / 2) clk = ~clk;

  mpser_rx #(.OSR(OSR_B), .DW(8)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .rx_en(rx_en), .mode(mode),
    .addr_en(addr_en), .own_addr(own), .addr_mask(mask), .flag_clr(flag_clr),
    .ferr_clr(ferr_clr), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
    .rx_flag(rx_flag), .ferr_flag(ferr_flag)
  );

  // per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (mon_on) begin
      total++;
      if ({rx_byte, rx_bit9, rx_flag, ferr_flag} !== {e_byte, e_b9, e_flag, e_ferr}) begin
        bad++;
        $display("FAIL %s per-clock act=%h exp=%h", cur,
                 {rx_byte, rx_bit9, rx_flag, ferr_flag}, {e_byte, e_b9, e_flag, e_ferr});
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, expv);
    end
  endtask

  task automatic put(input logic v);
    rxd = v; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic model(input logic [7:0] b, input logic b9, input logic stopv, input logic nine);
    logic [7:0] bc;
    bit hit, ok;
    bc  = own | mask;
    hit = (((b ^ own) & mask) == 8'h00) || ((b & bc) == bc);
    ok  = !addr_en || ((nine ? b9 : stopv) && hit);
    if (!stopv) e_ferr = 1'b1;
    if (ok && !e_flag) begin
      e_byte = b;
      e_b9   = nine ? b9 : stopv;
      e_flag = 1'b1;
    end
  endtask

  task automatic frame(input logic [7:0] b, input logic b9, input logic stopv,
                       input int gb, input bit drop);
    logic nine;
    bit   live;
    nine = mode[1];
    live = rx_en && (mode != 2'b00) && !drop;
    for (int k = 0; k < OSR_B; k++) put(1'b0);
    for (int i = 0; i < 8; i++) begin
      if (drop && i == 2) rx_en = 1'b0;
      for (int k = 0; k < OSR_B; k++) put((gb == i && k == OSR_B / 2) ? ~b[i] : b[i]);
    end
    if (nine) for (int k = 0; k < OSR_B; k++) put(b9);
    for (int k = 0; k < OSR_B; k++) begin
      rxd = stopv; tick = 1'b1;
      @(posedge clk);
      if (live && k == DECK) model(b, b9, stopv, nine);
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end
    for (int k = 0; k < 3 * OSR_B; k++) put(1'b1);
    if (drop) rx_en = 1'b1;
  endtask

  task automatic clr_flag;
    flag_clr = 1'b1;
    @(posedge clk); e_flag = 1'b0;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic clr_ferr;
    ferr_clr = 1'b1;
    @(posedge clk); e_ferr = 1'b0;
    @(negedge clk); ferr_clr = 1'b0;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-requirements act=hung exp=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; tick = 1'b0; rxd = 1'b1; rx_en = 1'b1; mode = 2'b01;
    addr_en = 1'b0; flag_clr = 1'b0; ferr_clr = 1'b0;
    own = 8'h42; mask = 8'hF3;
    repeat (4) @(negedge clk);
    chk("R12 reset outputs", {rx_byte, rx_bit9, rx_flag, ferr_flag}, 32'h0);
    rst = 1'b0; mon_on = 1'b1;
    for (int k = 0; k < 8; k++) put(1'b1);

    cur = "R1 R4 R8";
    frame(8'hA5, 1'b0, 1'b1, -1, 1'b0);
    chk("R4 flag after 8-bit frame", rx_flag, 1);
    chk("R1 byte LSB first", rx_byte, 8'hA5);
    chk("R8 stop bit in rx_bit9", rx_bit9, 1);
    clr_flag();

    cur = "R9";
    frame(8'h3C, 1'b0, 1'b0, -1, 1'b0);
    chk("R9 ferr on low stop", ferr_flag, 1);
    chk("R8 low stop in rx_bit9", rx_bit9, 0);
    clr_flag();
    frame(8'h11, 1'b0, 1'b1, -1, 1'b0);
    chk("R9 ferr kept by valid frame", ferr_flag, 1);
    clr_flag();
    clr_ferr();
    chk("R9 ferr cleared", ferr_flag, 0);

    cur = "R3";
    frame(8'h5A, 1'b0, 1'b1, 2, 1'b0);
    chk("R3 centre glitch voted out", rx_byte, 8'h5A);
    clr_flag();

    cur = "R2";
    put(1'b0);
    for (int k = 0; k < 3 * OSR_B; k++) put(1'b1);
    chk("R2 false start ignored", rx_flag, 0);
    frame(8'hC3, 1'b0, 1'b1, -1, 1'b0);
    chk("R2 recovery after false start", rx_byte, 8'hC3);
    clr_flag();

    cur = "R1 R8 nine";
    mode = 2'b10;
    frame(8'h81, 1'b0, 1'b1, -1, 1'b0);
    chk("R8 ninth bit 0", rx_bit9, 0);
    chk("R1 nine-bit byte", rx_byte, 8'h81);
    clr_flag();
    mode = 2'b11;
    frame(8'h7E, 1'b1, 1'b1, -1, 1'b0);
    chk("R8 ninth bit 1", rx_bit9, 1);
    clr_flag();

    cur = "R5 R7";
    addr_en = 1'b1;
    frame(8'h46, 1'b1, 1'b1, -1, 1'b0);
    chk("R7 given address accepted", rx_byte, 8'h46);
    clr_flag();
    frame(8'h4E, 1'b0, 1'b1, -1, 1'b0);
    chk("R5 ninth bit 0 rejected", rx_flag, 0);
    frame(8'h52, 1'b1, 1'b1, -1, 1'b0);
    chk("R7 mismatch rejected", rx_flag, 0);
    chk("R5 byte kept", rx_byte, 8'h46);
    frame(8'hF7, 1'b1, 1'b1, -1, 1'b0);
    chk("R7 broadcast accepted", rx_byte, 8'hF7);
    clr_flag();

    cur = "R6";
    mode = 2'b01;
    frame(8'h4A, 1'b0, 1'b1, -1, 1'b0);
    chk("R6 8-bit match accepted", rx_byte, 8'h4A);
    clr_flag();
    frame(8'h46, 1'b0, 1'b0, -1, 1'b0);
    chk("R6 bad stop rejected", rx_flag, 0);
    chk("R9 ferr on rejected frame", ferr_flag, 1);
    clr_ferr();
    frame(8'h52, 1'b0, 1'b1, -1, 1'b0);
    chk("R6 mismatch rejected", rx_flag, 0);

    cur = "R11";
    addr_en = 1'b0;
    frame(8'h99, 1'b0, 1'b1, -1, 1'b0);
    frame(8'h66, 1'b0, 1'b1, -1, 1'b0);
    chk("R11 flag held", rx_flag, 1);
    chk("R11 byte not overwritten", rx_byte, 8'h99);
    clr_flag();

    cur = "R10";
    rx_en = 1'b0;
    frame(8'h24, 1'b0, 1'b1, -1, 1'b0);
    rx_en = 1'b1;
    chk("R10 disabled frame ignored", rx_flag, 0);
    frame(8'h24, 1'b0, 1'b1, -1, 1'b1);
    chk("R10 aborted frame ignored", rx_flag, 0);
    mode = 2'b00;
    frame(8'h24, 1'b0, 1'b1, -1, 1'b0);
    chk("R10 mode 00 ignored", rx_flag, 0);
    chk("R10 byte kept", rx_byte, 8'h99);
    mode = 2'b01;
    frame(8'h24, 1'b0, 1'b1, -1, 1'b0);
    chk("R10 reception resumes", rx_byte, 8'h24);

    finish_run();
  end
endmodule